// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives a parallel character display module that has an 8-bit data bus and three control lines: register select, read/write and an enable strobe. A host hands it command bytes or character bytes over a valid/ready handshake. For each byte the controller sets the register select and the direction, drives the bus, and opens an enable window that is never shorter than the module's 450 ns minimum. Then it repeatedly reads the status register until the busy bit clears, and only after that does it accept the next byte.

After reset the controller sends a display-on command by itself, so the screen lights up without any help from the host. Two configuration inputs, captured while reset is asserted, choose whether that command turns on an underline cursor and a blinking cursor. If the status read still reports busy after a configured number of polls, a sticky error flag is raised and the controller goes back to accepting requests. All timing values are counts of clock cycles, derived from a clock-period parameter.

Top module: `lcd_wr_ctrl`

## Requirements
- R1: Once reset is released and before `req_ready` first rises, exactly one write is issued with `lcd_rs`=0, `lcd_rw`=0 and data `8'b0000_11UB`, where U and B are the values `cfg_ul` and `cfg_blink` held during reset. Changes to these inputs after reset have no effect.
- R2: A request with `req_char`=0 is written to the instruction register: `lcd_rs`=0, `lcd_rw`=0, and the bus carries `req_data` when `lcd_en` falls.
- R3: A request with `req_char`=1 is written to the data register: `lcd_rs`=1, `lcd_rw`=0, and the bus carries `req_data` when `lcd_en` falls.
- R4: Every `lcd_en` high pulse lasts exactly EN_CYC = ceil(450 / CLK_NS) clock cycles, so the pulse is at least 450 ns long.
- R5: `lcd_rs`, `lcd_rw`, `lcd_d_oe` and `lcd_d_out` stay unchanged for SETUP_CYC cycles before `lcd_en` rises, for the whole time it is high, and for HOLD_CYC cycles after it falls.
- R6: `lcd_d_oe` is 1 only while `lcd_rw`=0. During every status read (`lcd_rs`=0, `lcd_rw`=1) the bus is released.
- R7: After each write, status reads repeat until `lcd_busy_in` (bus bit 7) is sampled 0 in the last cycle of an enable pulse. `req_ready` stays 0 until that read completes.
- R8: If POLL_LIMIT status reads in a row all return busy, `err_timeout` is set and `req_ready` rises. `err_timeout` stays set until reset.
- R9: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle. A `req_valid` held while `req_ready` is 0 causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ul | input | 1 | Underline-cursor bit of the power-on command, captured during reset |
| cfg_blink | input | 1 | Blink bit of the power-on command, captured during reset |
| req_valid | input | 1 | Host has a byte to send |
| req_char | input | 1 | 1 = character (data register), 0 = command (instruction register) |
| req_data | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller can take a request |
| lcd_rs | output | 1 | Register select to the module |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe; the module latches on its falling edge |
| lcd_d_out | output | DATA_W | Value for the bus pads |
| lcd_d_oe | output | 1 | Drive enable for the bus pads |
| lcd_busy_in | input | 1 | Bit 7 of the bus as seen from the pad |
| err_timeout | output | 1 | Sticky flag: busy did not clear within POLL_LIMIT reads |

## Verification
The power-on command is checked under two different configuration settings, and the configuration is also changed after reset. Together these show that the cursor bits come from the values captured during reset. Commands and characters with different byte values show that register select follows the request kind and that the bus carries the requested byte. The busy model answers with zero, three or an endless run of busy reads. Counting the status reads in each case separates the correct stop-on-clear behaviour from polling that stops too early, polls too long, or never gives up. A request held while the controller is busy must leave the count of writes unchanged.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    PH_BOOT,
    PH_IDLE,
    PH_WSET,
    PH_WHI,
    PH_WHOLD,
    PH_RSET,
    PH_RHI,
    PH_RHOLD
  } phase_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len_m1,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len_m1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/lcd_poll_watch.sv
module lcd_poll_watch #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc)     cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl #(
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 8,
  parameter int EN_MIN_NS  = 450,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int POLL_LIMIT = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ul,
  input  logic              cfg_blink,
  input  logic              req_valid,
  input  logic              req_char,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en,
  output logic [DATA_W-1:0] lcd_d_out,
  output logic              lcd_d_oe,
  input  logic              lcd_busy_in,
  output logic              err_timeout
);
  import lcd_wr_pkg::*;

  localparam int EN_CYC  = ceil_div(EN_MIN_NS, CLK_NS);
  localparam int TMR_MAX = max3(EN_CYC, SETUP_CYC, HOLD_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [DATA_W-1:0] DISP_ON_BASE = DATA_W'(12);

  phase_e cur, nxt;
  logic   tmr_done, tmr_load;
  logic [TMR_W-1:0] tmr_len;
  logic   poll_last, poll_inc, poll_clr, err_set;
  logic   ul_q, bl_q, busy_q;
  logic   tx_rs, tx_rs_n;
  logic [DATA_W-1:0] tx_data, tx_data_n;
  logic   is_wr_n, is_rd_n;

  lcd_phase_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .len_m1(tmr_len), .done(tmr_done)
  );

  lcd_poll_watch #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clear(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  // next phase
  always_comb begin
    nxt = cur;
    unique case (cur)
      PH_BOOT:  nxt = PH_WSET;
      PH_IDLE:  if (req_valid && req_ready) nxt = PH_WSET;
      PH_WSET:  if (tmr_done) nxt = PH_WHI;
      PH_WHI:   if (tmr_done) nxt = PH_WHOLD;
      PH_WHOLD: if (tmr_done) nxt = PH_RSET;
      PH_RSET:  if (tmr_done) nxt = PH_RHI;
      PH_RHI:   if (tmr_done) nxt = PH_RHOLD;
      PH_RHOLD: if (tmr_done) nxt = (busy_q && !poll_last) ? PH_RSET : PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  // phase lengths
  always_comb begin
    tmr_load = (nxt != cur);
    unique case (nxt)
      PH_WHI, PH_RHI:     tmr_len = TMR_W'(EN_CYC - 1);
      PH_WHOLD, PH_RHOLD: tmr_len = TMR_W'(HOLD_CYC - 1);
      default:            tmr_len = TMR_W'(SETUP_CYC - 1);
    endcase
  end

  assign poll_clr = (cur == PH_WSET);
  assign poll_inc = (cur == PH_RHOLD) && tmr_done && busy_q && !poll_last;
  assign err_set  = (cur == PH_RHOLD) && tmr_done && busy_q && poll_last;

  // byte selection for the next write
  always_comb begin
    tx_rs_n   = tx_rs;
    tx_data_n = tx_data;
    if (cur == PH_BOOT) begin
      tx_rs_n   = 1'b0;
      tx_data_n = DISP_ON_BASE | DATA_W'({ul_q, bl_q});
    end else if (cur == PH_IDLE && req_valid && req_ready) begin
      tx_rs_n   = req_char;
      tx_data_n = req_data;
    end
  end

  assign is_wr_n = (nxt == PH_WSET) || (nxt == PH_WHI) || (nxt == PH_WHOLD);
  assign is_rd_n = (nxt == PH_RSET) || (nxt == PH_RHI) || (nxt == PH_RHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur         <= PH_BOOT;
      ul_q        <= cfg_ul;
      bl_q        <= cfg_blink;
      busy_q      <= 1'b0;
      tx_rs       <= 1'b0;
      tx_data     <= '0;
      req_ready   <= 1'b0;
      lcd_rs      <= 1'b0;
      lcd_rw      <= 1'b0;
      lcd_en      <= 1'b0;
      lcd_d_out   <= '0;
      lcd_d_oe    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      cur       <= nxt;
      tx_rs     <= tx_rs_n;
      tx_data   <= tx_data_n;
      if (cur == PH_RHI && tmr_done) busy_q <= lcd_busy_in;
      if (err_set) err_timeout <= 1'b1;
      req_ready <= (nxt == PH_IDLE);
      lcd_rs    <= is_wr_n ? tx_rs_n : 1'b0;
      lcd_rw    <= is_rd_n;
      lcd_en    <= (nxt == PH_WHI) || (nxt == PH_RHI);
      lcd_d_oe  <= is_wr_n;
      lcd_d_out <= is_wr_n ? tx_data_n : '0;
    end
  end
endmodule

// File: rtl/lcd_wr_ctrl_chk.sv
module lcd_wr_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int EN_CYC    = 57,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              lcd_rs,
  input logic              lcd_rw,
  input logic              lcd_en,
  input logic [DATA_W-1:0] lcd_d_out,
  input logic              lcd_d_oe,
  input logic              err_timeout
);
  logic [DATA_W+2:0] sig, sig_p;
  logic diff;
  int   en_cnt, stab_cnt, hold_cnt;

  assign sig  = {lcd_rs, lcd_rw, lcd_d_oe, lcd_d_out};
  assign diff = (sig != sig_p);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_p    <= sig;
      en_cnt   <= 0;
      stab_cnt <= 0;
      hold_cnt <= 0;
    end else begin
      sig_p    <= sig;
      en_cnt   <= lcd_en ? en_cnt + 1 : 0;
      stab_cnt <= diff ? 0 : ((stab_cnt < SETUP_CYC) ? stab_cnt + 1 : stab_cnt);
      if (!lcd_en && en_cnt != 0) hold_cnt <= HOLD_CYC - 1;
      else if (hold_cnt != 0)     hold_cnt <= hold_cnt - 1;
    end
  end

  // R4: enable high time
  assert_en_width_R4: assert property (@(posedge clk) disable iff (rst)
    (!lcd_en && en_cnt != 0) |-> (en_cnt == EN_CYC));

  // R5: setup before rise, stable while high, hold after fall
  assert_setup_R5: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && en_cnt == 0) |-> (!diff && stab_cnt >= SETUP_CYC - 1));
  assert_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && en_cnt != 0) |-> !diff);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((!lcd_en && en_cnt != 0) || hold_cnt != 0) |-> !diff);

  // R6: bus driven only for writes
  assert_oe_write_R6: assert property (@(posedge clk) disable iff (rst)
    lcd_d_oe |-> !lcd_rw);
  assert_read_rs_R6: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> (!lcd_rs && !lcd_d_oe));

  // R7: no handshake while a strobe is active
  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !lcd_en);

  // R8: error is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_timeout |=> err_timeout);

  // R9: ready drops after acceptance
  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind lcd_wr_ctrl lcd_wr_ctrl_chk #(
  .DATA_W(DATA_W), .EN_CYC(EN_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d_out(lcd_d_out),
  .lcd_d_oe(lcd_d_oe), .err_timeout(err_timeout)
);

// File: tb/test_lcd_wr_ctrl.sv
`timescale 1ns/1ps
module test_lcd_wr_ctrl;
  localparam int CLK_NS = 8;
  localparam int EN_EXP = (450 + CLK_NS - 1) / CLK_NS;
  localparam int PLIM   = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_ul = 1'b1, cfg_blink = 1'b0;
  logic       req_valid = 1'b0, req_char = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       req_ready, lcd_rs, lcd_rw, lcd_en, lcd_d_oe, lcd_busy_in, err_timeout;
  logic [7:0] lcd_d_out;

  int n_tests = 0, n_fail = 0;
  int busy_cfg = 0, busy_left = 0;
  int wr_n = 0, rd_n = 0, en_run = 0, en_last = 0, rd_oe_bad = 0;
  logic       wr_rs [0:63];
  logic [7:0] wr_d  [0:63];

  always #4 clk = ~clk;

  lcd_wr_ctrl #(.CLK_NS(CLK_NS), .POLL_LIMIT(PLIM)) i_lcd_wr_ctrl (
    .clk(clk), .rst(rst), .cfg_ul(cfg_ul), .cfg_blink(cfg_blink),
    .req_valid(req_valid), .req_char(req_char), .req_data(req_data),
    .req_ready(req_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_busy_in(lcd_busy_in),
    .err_timeout(err_timeout)
  );

  // display module model
  assign lcd_busy_in = (busy_left != 0);

  always @(negedge lcd_en) begin
    if (!lcd_rw) begin
      if (wr_n < 64) begin
        wr_rs[wr_n] = lcd_rs;
        wr_d[wr_n]  = lcd_d_out;
      end
      wr_n++;
      busy_left = busy_cfg;
    end else begin
      rd_n++;
      if (busy_left > 0) busy_left--;
    end
  end

  always @(negedge clk) begin
    if (lcd_en) en_run++;
    else if (en_run != 0) begin
      en_last = en_run;
      en_run  = 0;
    end
    if (lcd_rw && lcd_d_oe) rd_oe_bad++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic send(input bit is_char, input logic [7:0] b);
    wait_ready();
    req_valid = 1'b1;
    req_char  = is_char;
    req_data  = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset(input bit ul, input bit bl);
    @(negedge clk);
    rst = 1'b1; cfg_ul = ul; cfg_blink = bl;
    busy_cfg = 0; busy_left = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 1'b0);
    chk(!req_ready && !lcd_en && !lcd_d_oe && !err_timeout, "R1 reset outputs quiet",
        {req_ready, lcd_en, lcd_d_oe, err_timeout}, 0);
  endtask

  task automatic t_boot(input bit ul, input bit bl);
    int w0;
    w0 = wr_n;
    cfg_ul = ~ul; cfg_blink = ~bl;      // changes after reset must not matter
    wait_ready();
    chk(wr_n == w0 + 1, "R1 one power-on write", wr_n - w0, 1);
    chk(wr_rs[w0] == 1'b0, "R1 power-on rs", wr_rs[w0], 0);
    chk(wr_d[w0] == {6'b000011, ul, bl}, "R1 power-on byte", wr_d[w0], {6'b000011, ul, bl});
  endtask

  task automatic t_write(input bit is_char, input logic [7:0] b, input int busy_n);
    int w0, r0;
    w0 = wr_n; r0 = rd_n; busy_cfg = busy_n;
    send(is_char, b);
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    wait_ready();
    chk(wr_n == w0 + 1, is_char ? "R3 one write" : "R2 one write", wr_n - w0, 1);
    chk(wr_rs[w0] == is_char, is_char ? "R3 rs high" : "R2 rs low", wr_rs[w0], is_char);
    chk(wr_d[w0] == b, is_char ? "R3 data" : "R2 data", wr_d[w0], b);
    chk(rd_n - r0 == busy_n + 1, "R7 status reads until clear", rd_n - r0, busy_n + 1);
    chk(en_last == EN_EXP && en_last * CLK_NS >= 450, "R4 enable width", en_last, EN_EXP);
  endtask

  task automatic t_held_valid();
    int w0;
    w0 = wr_n; busy_cfg = 2;
    send(1'b1, 8'h5A);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_char = 1'b0; req_data = 8'hC3;
    repeat (100) @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 still busy during held valid", req_ready, 0);
    wait_ready();
    chk(wr_n == w0 + 1, "R9 held valid ignored", wr_n - w0, 1);
    chk(wr_d[w0] == 8'h5A, "R9 accepted byte", wr_d[w0], 8'h5A);
  endtask

  task automatic t_timeout();
    int r0;
    r0 = rd_n; busy_cfg = 100000;
    send(1'b0, 8'h01);
    chk(!err_timeout, "R8 no error early", err_timeout, 0);
    wait_ready();
    chk(err_timeout, "R8 error raised", err_timeout, 1);
    chk(rd_n - r0 == PLIM, "R8 poll count", rd_n - r0, PLIM);
    t_write(1'b1, 8'h33, 0);
    chk(err_timeout, "R8 error sticky", err_timeout, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_boot(1'b1, 1'b0);
    t_write(1'b0, 8'h01, 0);
    t_write(1'b1, 8'h41, 3);
    t_write(1'b1, 8'hA7, 1);
    t_write(1'b0, 8'h80, 5);
    t_held_valid();
    t_timeout();
    chk(rd_oe_bad == 0, "R6 bus released on reads", rd_oe_bad, 0);
    do_reset(1'b0, 1'b1);
    chk(!err_timeout, "R8 cleared by reset", err_timeout, 0);
    t_boot(1'b0, 1'b1);
    t_write(1'b1, 8'h7E, 2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule